// File: doc/BRIEF.md
# Claim/Complete External Interrupt Controller

This block collects up to 31 level-sensitive interrupt lines and presents a single external-interrupt request to one hart. Each line is sampled into a pending bit every clock. A second per-line bit records that software has taken the interrupt and is still servicing it. The request output is high whenever some line is pending and not marked as in service. The same output drives both the machine-level and the supervisor-level external request.

Software reaches the block over a simple 32-bit register bus with one combined claim/complete register. A read of that register returns the lowest-numbered source that is pending and not in service, and marks that source as in service. A write of a source number to the same register ends service for that source. There are no priorities, no enable masks and no threshold. The threshold location reads as zero. Source number 0 is reserved and means "nothing to claim".

Top module: `irq_claim_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `ext_irq` is 0, no source is in service and `bus_rdata` is 0.
- R2: Line `src_lvl[k]` is source number k+1. Its pending bit takes the line level at every clock edge. It is set while the line is high and cleared as soon as the line is low, whatever its service state.
- R3: `ext_irq` is high exactly when some source is pending and not in service. It changes at the clock edge that samples the line or that performs the claim or complete access.
- R4: A read of byte offset 0x200004 (the claim/complete register) returns, in the cycle after the access, the number of the lowest-numbered pending source that is not in service. The same edge marks that source as in service.
- R5: A claim read when no source is both pending and not in service returns 0 and leaves every in-service bit unchanged.
- R6: A write of a value n, with 1 <= n <= 31, to offset 0x200004 ends service for source n. That source is then eligible again if its line is still high.
- R7: A completion write of 0, or of any value above 31, changes nothing.
- R8: A read of offset 0x200000 (the threshold location) returns 0. Reads of any other offset return 0, and writes to any offset other than 0x200004 change nothing.
- R9: A claimed source whose line stays high, or drops and rises again, does not raise `ext_irq` and cannot be claimed again until it is completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 31 | Interrupt line levels; bit k is source k+1 |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| ext_irq | output | 1 | Combined external-interrupt request to the hart |

## Verification
The bench sweeps all 31 sources one at a time through raise, claim, complete and drop. A design with a shifted source number would return the wrong ID. A design that forgot to mark the source would keep `ext_irq` high after the claim. It then applies dense and sparse multi-line masks and drains them by repeated claims. The claims must come back in ascending order and end with a 0 read. A wrong priority encoder would break that order, and a claim on empty would corrupt the in-service set. It also writes completion values 0, 32 and all-ones, and accesses stray offsets. A design that wrapped 0 to source 32, or that truncated 33 to source 1, would be caught by a later claim that returns an ID it should not.

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int NSRC   = 31,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] THRESH_OFF = 24'h200000,
  parameter logic [ADDR_W-1:0] CLAIM_OFF  = 24'h200004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ext_irq
);
  localparam int IDX_W = $clog2(NSRC + 1);

  logic [NSRC-1:0]  pend_q, srv_q;
  logic [NSRC-1:0]  elig, take_mask, done_mask;
  logic [IDX_W-1:0] take_idx;
  logic             take_any;
  logic             claim_rd, cmpl_wr, cmpl_ok;

  assign elig     = pend_q & ~srv_q;
  assign ext_irq  = |elig;
  assign claim_rd = bus_en && !bus_we && (bus_addr == CLAIM_OFF);
  assign cmpl_wr  = bus_en &&  bus_we && (bus_addr == CLAIM_OFF);
  assign cmpl_ok  = (bus_wdata != '0) && (bus_wdata <= DATA_W'(NSRC));

  always_comb begin
    take_idx = '0;
    take_any = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        take_idx = IDX_W'(i);
        take_any = 1'b1;
      end
    end
  end

  assign take_mask = (claim_rd && take_any) ? (NSRC'(1) << take_idx) : '0;
  assign done_mask = (cmpl_wr && cmpl_ok)
                     ? (NSRC'(1) << (bus_wdata[IDX_W-1:0] - IDX_W'(1))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      srv_q     <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q <= src_lvl;
      srv_q  <= (srv_q | take_mask) & ~done_mask;
      if (claim_rd && take_any) bus_rdata <= DATA_W'(take_idx) + DATA_W'(1);
      else                      bus_rdata <= '0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (srv_q == '0 && bus_rdata == '0 && !ext_irq));

  assert_req_needs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> (|$past(src_lvl)));

  assert_claim_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(claim_rd) && bus_rdata != '0)
      |-> srv_q[bus_rdata[IDX_W-1:0] - IDX_W'(1)]);

  assert_one_claim_per_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(srv_q) <= $countones($past(srv_q)) + 1);

  assert_empty_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(claim_rd) && bus_rdata == '0) |-> (srv_q == $past(srv_q)));

  assert_bad_id_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmpl_wr) && !$past(cmpl_ok)) |-> (srv_q == $past(srv_q)));

  assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en && bus_we && bus_addr != CLAIM_OFF) |-> (srv_q == $past(srv_q)));
endmodule

// File: tb/irq_claim_ctrl_tb.sv
module irq_claim_ctrl_tb;
  localparam int N = 31;
  localparam logic [23:0] THR = 24'h200000;
  localparam logic [23:0] CLM = 24'h200004;

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] src_lvl = '0;
  logic        bus_en = 0, bus_we = 0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ext_irq;

  int vecs = 0, errs = 0;
  logic [N-1:0] m_pend = '0, m_srv = '0;

  always #4 clk = ~clk;

  irq_claim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_irq(ext_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_claim();
    for (int i = 0; i < N; i++) if (m_pend[i] && !m_srv[i]) return 32'(i + 1);
    return 0;
  endfunction

  task automatic lines(input logic [N-1:0] v);
    @(negedge clk);
    src_lvl = v; m_pend = v;
    @(negedge clk);
    chk("R2/R3 ext_irq after line change", 32'(ext_irq), 32'(|(m_pend & ~m_srv)));
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic claim(input string tag);
    logic [31:0] e, d;
    e = exp_claim();
    rd(CLM, d);
    chk(tag, d, e);
    if (e != 0) m_srv[e-1] = 1'b1;
    chk("R3 ext_irq after claim", 32'(ext_irq), 32'(|(m_pend & ~m_srv)));
  endtask

  task automatic complete(input logic [31:0] id);
    wr(CLM, id);
    if (id >= 1 && id <= N) m_srv[id-1] = 1'b0;
    chk("R6/R7 ext_irq after complete", 32'(ext_irq), 32'(|(m_pend & ~m_srv)));
  endtask

  initial begin
    #400000;
    errs++; vecs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 ext_irq in reset", 32'(ext_irq), 0);
    chk("R1 rdata in reset", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ext_irq after reset", 32'(ext_irq), 0);
    claim("R5 claim after reset empty");

    for (int k = 1; k <= N; k++) begin
      lines(N'(1) << (k - 1));
      claim("R4 single source claim");
      claim("R9 no second claim");
      lines('0);
      lines(N'(1) << (k - 1));
      chk("R9 re-raise while served", 32'(ext_irq), 0);
      complete(32'(k));
      claim("R6 reclaim after complete");
      complete(32'(k));
      lines('0);
    end

    foreach (d[i]) begin end
    for (int p = 0; p < 6; p++) begin
      logic [N-1:0] m;
      case (p)
        0: m = '1;
        1: m = N'(31'h5555_5555);
        2: m = N'(31'h4000_0001);
        3: m = N'(31'h0F0F_00F0);
        4: m = N'(31'h2AAA_AAAA);
        default: m = N'(31'h0001_8000);
      endcase
      lines(m);
      for (int c = 0; c <= $countones(m); c++) claim("R4/R5 drain in ascending order");
      complete(0);
      claim("R7 id 0 ignored");
      complete(32);
      claim("R7 id 32 ignored");
      complete(33);
      claim("R7 id 33 ignored");
      complete(32'hFFFF_FFFF);
      claim("R7 id all-ones ignored");
      wr(THR, 32'd5);
      wr(24'h000010, 32'd1);
      claim("R8 stray write ignored");
      rd(THR, d);
      chk("R8 threshold reads zero", d, 0);
      rd(24'h000000, d);
      chk("R8 other offset reads zero", d, 0);
      for (int i = 1; i <= N; i++) if (m[i-1]) complete(32'(i));
      lines(m & N'(31'h7FFF_FFFE));
      claim("R2 pending follows dropped line");
      lines('0);
      for (int i = 1; i <= N; i++) complete(32'(i));
      chk("R2 lines low output low", 32'(ext_irq), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule